// File: doc/BRIEF.md
# Workspace Context Switch Sequencer

This block runs the context switch of a processor whose general registers are not held on chip. They live in ordinary memory, in a sixteen-register window that starts at the workspace pointer. Register n of the current window sits at byte address WP + 2·n, and its most significant byte is the even address of that word. The block holds the three live control registers: workspace pointer, program counter and status word. It drives a single word-wide memory port that waits on a ready handshake.

A vectored call reads a two-word vector from memory. The first word is the new workspace pointer and the second is the new program counter. The block writes the caller's state into the new window: the old workspace pointer goes to register 13, the resume PC to register 14 and the old status to register 15. It then switches to the new pointer and PC. The resume PC is supplied with the request and points just past the calling instruction, so the callee can step register 14 forward to read inline parameters.

A return reloads the pointer, PC and status from registers 13 to 15 of the current window. A maskable interrupt of level k is an implicit vectored call through byte address 4·k. It saves the current PC and lowers the status mask to k−1. Requests are only sampled between operations.

Top module: `ctxsw_top`

## Requirements
- R1: After reset, wp = 0x0000, pc = 0x0000, st = 0x000F, busy = 0 and no memory access is requested.
- R2: A call reads the word at call_vec (bit 0 ignored) as the new WP and the word two bytes above it as the new PC. When the call ends, wp and pc hold these values and st is unchanged.
- R3: A call stores the old WP at newWP+26 (register 13), call_link_pc at newWP+28 (register 14) and the old status at newWP+30 (register 15).
- R4: A return loads wp, pc and st from the words at WP+26, WP+28 and WP+30 of the current workspace, in that order.
- R5: An interrupt of level k (1 to 15) is accepted when k ≤ st[3:0]. It vectors through byte address 4·k, saves the current pc as the resume PC, and leaves st[3:0] = k−1 with st[15:4] kept.
- R6: An interrupt request with level 0, or with a level above st[3:0], has no effect: no memory access is made and wp, pc and st are unchanged.
- R7: When requests arrive in the same idle cycle, the order is call first, then return, then interrupt. A held interrupt request is taken at the next idle boundary.
- R8: Each access holds address, direction and data until mem_rdy is high. Exactly one access completes per cycle in which mem_req and mem_rdy are both high.
- R9: Every memory address issued has bit 0 equal to 0.
- R10: Requests are sampled only while busy is low. A request that arrives during an operation is dropped. wp, pc and st change only in the cycle in which an operation finishes.
- R11: A call performs exactly five accesses in this order: vector read at +0, vector read at +2, then writes to registers 13, 14 and 15. A return performs exactly three reads, of registers 13, 14 and 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_req | input | 1 | Start a vectored call |
| call_vec | input | 16 | Byte address of the call vector |
| call_link_pc | input | 16 | Resume PC to save for the call |
| ret_req | input | 1 | Start a return from the current workspace |
| irq_req | input | 1 | Interrupt request |
| irq_level | input | 4 | Interrupt level |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Word-aligned byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data |
| mem_rdy | input | 1 | Access completes this cycle |
| wp | output | 16 | Workspace pointer |
| pc | output | 16 | Program counter |
| st | output | 16 | Status word, mask in bits 3:0 |

## Verification
The hardest condition to reach from the ports is a nested interrupt. It needs a status mask lowered by an earlier interrupt, a request above that mask that must be refused, and then a request at or below it that must be taken. The bench first reaches a chosen status value through a crafted return frame. It then takes a level-3 interrupt, holds a level-5 request that must stay pending, and raises level 2 to nest. It unwinds with two returns and checks every saved frame in memory. The same-cycle collision of call, return and interrupt is produced by asserting all three on one idle edge and holding only the interrupt afterwards.

// File: rtl/ctxsw_pkg.sv
package ctxsw_pkg;

    localparam int unsigned WORD_W      = 16;
    localparam int unsigned VEC_SHIFT   = 2;
    localparam int unsigned REG_OLD_WP  = 13;
    localparam int unsigned REG_OLD_PC  = 14;
    localparam int unsigned REG_OLD_ST  = 15;
    localparam int unsigned BYTES_PER_W = WORD_W / 8;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_VEC_WP,
        PH_VEC_PC,
        PH_PUT_WP,
        PH_PUT_PC,
        PH_PUT_ST,
        PH_GET_WP,
        PH_GET_PC,
        PH_GET_ST
    } phase_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_CALL,
        OP_RET,
        OP_IRQ
    } op_e;

    function automatic word_t word_align(input word_t a);
        return a & ~word_t'(1);
    endfunction

    function automatic word_t reg_addr(input word_t base, input int unsigned idx);
        return word_align(base + word_t'(idx * BYTES_PER_W));
    endfunction

endpackage

// File: rtl/ctxsw_arbiter.sv
module ctxsw_arbiter
    import ctxsw_pkg::*;
#(
    parameter int unsigned LVL_W = 4
) (
    input  logic             call_req,
    input  logic             ret_req,
    input  logic             irq_req,
    input  logic [LVL_W-1:0] irq_level,
    input  logic [LVL_W-1:0] mask,
    input  word_t            call_vec,
    output op_e              op,
    output word_t            vec_addr
);

    logic irq_ok;

    always_comb begin
        irq_ok   = irq_req && (irq_level != '0) && (irq_level <= mask);
        op       = OP_NONE;
        vec_addr = word_align(call_vec);
        if (call_req) begin
            op = OP_CALL;
        end else if (ret_req) begin
            op = OP_RET;
        end else if (irq_ok) begin
            op       = OP_IRQ;
            vec_addr = word_t'(irq_level) << VEC_SHIFT;
        end
    end

endmodule

// File: rtl/ctxsw_addrgen.sv
module ctxsw_addrgen
    import ctxsw_pkg::*;
(
    input  phase_e phase,
    input  word_t  vec_base,
    input  word_t  new_wp,
    input  word_t  cur_wp,
    output logic   req,
    output logic   we,
    output word_t  addr
);

    word_t raw;

    always_comb begin
        req = 1'b1;
        we  = 1'b0;
        raw = '0;
        unique case (phase)
            PH_VEC_WP: raw = vec_base;
            PH_VEC_PC: raw = vec_base + word_t'(BYTES_PER_W);
            PH_PUT_WP: begin raw = reg_addr(new_wp, REG_OLD_WP); we = 1'b1; end
            PH_PUT_PC: begin raw = reg_addr(new_wp, REG_OLD_PC); we = 1'b1; end
            PH_PUT_ST: begin raw = reg_addr(new_wp, REG_OLD_ST); we = 1'b1; end
            PH_GET_WP: raw = reg_addr(cur_wp, REG_OLD_WP);
            PH_GET_PC: raw = reg_addr(cur_wp, REG_OLD_PC);
            PH_GET_ST: raw = reg_addr(cur_wp, REG_OLD_ST);
            default:   req = 1'b0;
        endcase
        addr = word_align(raw);
    end

endmodule

// File: rtl/ctxsw_top.sv
module ctxsw_top
    import ctxsw_pkg::*;
#(
    parameter int unsigned LVL_W    = 4,
    parameter logic [15:0] RESET_ST = 16'h000F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             call_req,
    input  logic [15:0]      call_vec,
    input  logic [15:0]      call_link_pc,
    input  logic             ret_req,
    input  logic             irq_req,
    input  logic [LVL_W-1:0] irq_level,
    output logic             busy,
    output logic             mem_req,
    output logic             mem_we,
    output logic [15:0]      mem_addr,
    output logic [15:0]      mem_wdata,
    input  logic [15:0]      mem_rdata,
    input  logic             mem_rdy,
    output logic [15:0]      wp,
    output logic [15:0]      pc,
    output logic [15:0]      st
);

    typedef struct packed {
        phase_e           phase;
        word_t            wp;
        word_t            pc;
        word_t            st;
        word_t            tmp_wp;
        word_t            tmp_pc;
        word_t            vec_base;
        word_t            link_pc;
        logic             is_irq;
        logic [LVL_W-1:0] lvl;
    } ctx_t;

    ctx_t  ctx_q, ctx_d;
    op_e   op_sel;
    word_t vec_sel;
    logic  step;

    ctxsw_arbiter #(.LVL_W(LVL_W)) u_arb (
        .call_req  (call_req),
        .ret_req   (ret_req),
        .irq_req   (irq_req),
        .irq_level (irq_level),
        .mask      (ctx_q.st[LVL_W-1:0]),
        .call_vec  (call_vec),
        .op        (op_sel),
        .vec_addr  (vec_sel)
    );

    ctxsw_addrgen u_agen (
        .phase    (ctx_q.phase),
        .vec_base (ctx_q.vec_base),
        .new_wp   (ctx_q.tmp_wp),
        .cur_wp   (ctx_q.wp),
        .req      (mem_req),
        .we       (mem_we),
        .addr     (mem_addr)
    );

    assign step = mem_req && mem_rdy;

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.phase)
            PH_IDLE: begin
                if (op_sel != OP_NONE) begin
                    ctx_d.vec_base = vec_sel;
                    ctx_d.link_pc  = (op_sel == OP_CALL) ? call_link_pc : ctx_q.pc;
                    ctx_d.is_irq   = (op_sel == OP_IRQ);
                    ctx_d.lvl      = irq_level;
                    ctx_d.phase    = (op_sel == OP_RET) ? PH_GET_WP : PH_VEC_WP;
                end
            end
            PH_VEC_WP: if (step) begin
                ctx_d.tmp_wp = mem_rdata;
                ctx_d.phase  = PH_VEC_PC;
            end
            PH_VEC_PC: if (step) begin
                ctx_d.tmp_pc = mem_rdata;
                ctx_d.phase  = PH_PUT_WP;
            end
            PH_PUT_WP: if (step) ctx_d.phase = PH_PUT_PC;
            PH_PUT_PC: if (step) ctx_d.phase = PH_PUT_ST;
            PH_PUT_ST: if (step) begin
                ctx_d.wp    = ctx_q.tmp_wp;
                ctx_d.pc    = ctx_q.tmp_pc;
                if (ctx_q.is_irq) begin
                    ctx_d.st[LVL_W-1:0] = ctx_q.lvl - LVL_W'(1);
                end
                ctx_d.phase = PH_IDLE;
            end
            PH_GET_WP: if (step) begin
                ctx_d.tmp_wp = mem_rdata;
                ctx_d.phase  = PH_GET_PC;
            end
            PH_GET_PC: if (step) begin
                ctx_d.tmp_pc = mem_rdata;
                ctx_d.phase  = PH_GET_ST;
            end
            PH_GET_ST: if (step) begin
                ctx_d.wp    = ctx_q.tmp_wp;
                ctx_d.pc    = ctx_q.tmp_pc;
                ctx_d.st    = mem_rdata;
                ctx_d.phase = PH_IDLE;
            end
            default: ctx_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q    <= '0;
            ctx_q.st <= RESET_ST;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    always_comb begin
        unique case (ctx_q.phase)
            PH_PUT_WP: mem_wdata = ctx_q.wp;
            PH_PUT_PC: mem_wdata = ctx_q.link_pc;
            PH_PUT_ST: mem_wdata = ctx_q.st;
            default:   mem_wdata = '0;
        endcase
    end

    assign busy = (ctx_q.phase != PH_IDLE);
    assign wp   = ctx_q.wp;
    assign pc   = ctx_q.pc;
    assign st   = ctx_q.st;

endmodule

// File: rtl/ctxsw_checker.sv
module ctxsw_checker #(
    parameter int unsigned LVL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             call_req,
    input logic             ret_req,
    input logic             irq_req,
    input logic [LVL_W-1:0] irq_level,
    input logic             busy,
    input logic             mem_req,
    input logic             mem_we,
    input logic [15:0]      mem_addr,
    input logic             mem_rdy,
    input logic [15:0]      wp,
    input logic [15:0]      pc,
    input logic [15:0]      st
);

    p_even_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !mem_addr[0]);

    p_hold_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rdy |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    p_regs_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(wp) && $stable(pc) && $stable(st));

    p_irq_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !call_req && !ret_req && irq_req &&
        ((irq_level == '0) || (irq_level > st[LVL_W-1:0])) |=> !busy);

    p_start_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(call_req || ret_req || irq_req));

endmodule

bind ctxsw_top ctxsw_checker #(.LVL_W(LVL_W)) u_ctxsw_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .call_req  (call_req),
    .ret_req   (ret_req),
    .irq_req   (irq_req),
    .irq_level (irq_level),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_rdy   (mem_rdy),
    .wp        (wp),
    .pc        (pc),
    .st        (st)
);

// File: tb/ctxsw_top_test.sv
module ctxsw_top_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_req = 1'b0, ret_req = 1'b0, irq_req = 1'b0;
    logic [15:0] call_vec = '0, call_link_pc = '0;
    logic [3:0]  irq_level = '0;
    logic        busy, mem_req, mem_we, mem_rdy;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, wp, pc, st;

    logic [15:0] mem [0:255];
    logic        poke_en = 1'b0;
    logic [15:0] poke_a = '0, poke_d = '0;
    int          log_n;
    logic [15:0] log_a [0:511];
    logic        log_w [0:511];
    int          stall = 0;
    int          rcnt = 0;
    int          n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctxsw_top uut (
        .clk(clk), .rst_n(rst_n), .call_req(call_req), .call_vec(call_vec),
        .call_link_pc(call_link_pc), .ret_req(ret_req), .irq_req(irq_req),
        .irq_level(irq_level), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rdy(mem_rdy), .wp(wp), .pc(pc), .st(st)
    );

    always @(negedge clk) rcnt <= rcnt + 1;
    assign mem_rdy   = (stall == 0) || ((rcnt % (stall + 1)) == 0);
    assign mem_rdata = mem[mem_addr[8:1]];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 256; k++) mem[k] <= 16'h0;
            log_n <= 0;
        end else begin
            if (poke_en) mem[poke_a[8:1]] <= poke_d;
            if (mem_req && mem_rdy) begin
                log_a[log_n % 512] <= mem_addr;
                log_w[log_n % 512] <= mem_we;
                log_n <= log_n + 1;
                if (mem_we) mem[mem_addr[8:1]] <= mem_wdata;
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] peek(input logic [15:0] a);
        return mem[a[8:1]];
    endfunction

    task automatic poke(input logic [15:0] a, input logic [15:0] d);
        poke_a = a; poke_d = d; poke_en = 1'b1;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic wait_idle();
        int g = 0;
        while (busy && g < 2000) begin @(negedge clk); g++; end
        if (busy) begin n_fail++; $display("FAIL R8 operation never finished: actual busy 1 expected 0"); end
    endtask

    task automatic do_call(input logic [15:0] v, input logic [15:0] link);
        call_vec = v; call_link_pc = link; call_req = 1'b1;
        @(negedge clk);
        call_req = 1'b0;
        wait_idle();
    endtask

    task automatic do_ret();
        ret_req = 1'b1;
        @(negedge clk);
        ret_req = 1'b0;
        wait_idle();
    endtask

    task automatic do_irq(input logic [3:0] k);
        irq_level = k; irq_req = 1'b1;
        @(negedge clk);
        irq_req = 1'b0;
        wait_idle();
    endtask

    task automatic chk_acc(input string req, input int idx, input logic [15:0] a, input logic w);
        chk(req, "access address", log_a[idx % 512], a);
        chk(req, "access direction", {15'd0, log_w[idx % 512]}, {15'd0, w});
    endtask

    initial begin
        logic [15:0] nwp, npc, vb, lk, ow, op, os;
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "wp", wp, 16'h0000);
        chk("R1", "pc", pc, 16'h0000);
        chk("R1", "st", st, 16'h000F);
        chk("R1", "busy", {15'd0, busy}, 16'h0);
        chk("R1", "mem_req", {15'd0, mem_req}, 16'h0);

        // R2 R3 R4 R8 R9 R11: call/return sweep over stall patterns
        for (int s = 0; s < 4; s++) begin
            for (int i = 0; i < 4; i++) begin
                stall = s;
                nwp = 16'h0100 + 16'(i * 32);
                npc = 16'h2000 + 16'(i * 256 + s * 2);
                vb  = 16'h0040 + 16'(i * 4);
                lk  = 16'h3000 + 16'(s * 16 + i * 2);
                ow = wp; op = pc; os = st;
                poke(vb, nwp);
                poke(vb + 16'd2, npc);
                base = log_n;
                do_call(vb | 16'h1, lk);
                chk("R2", "call wp", wp, nwp);
                chk("R2", "call pc", pc, npc);
                chk("R2", "call st", st, os);
                chk("R3", "saved wp", peek(nwp + 16'd26), ow);
                chk("R3", "saved pc", peek(nwp + 16'd28), lk);
                chk("R3", "saved st", peek(nwp + 16'd30), os);
                chk("R11", "call access count", 16'(log_n - base), 16'd5);
                chk_acc("R11", base,     vb,             1'b0);
                chk_acc("R11", base + 1, vb + 16'd2,     1'b0);
                chk_acc("R11", base + 2, nwp + 16'd26,   1'b1);
                chk_acc("R11", base + 3, nwp + 16'd28,   1'b1);
                chk_acc("R11", base + 4, nwp + 16'd30,   1'b1);
                poke(nwp + 16'd28, lk + 16'd2);
                base = log_n;
                do_ret();
                chk("R4", "ret wp", wp, ow);
                chk("R4", "ret pc (inline step)", pc, lk + 16'd2);
                chk("R4", "ret st", st, os);
                chk("R11", "ret access count", 16'(log_n - base), 16'd3);
                chk_acc("R11", base,     nwp + 16'd26, 1'b0);
                chk_acc("R11", base + 1, nwp + 16'd28, 1'b0);
                chk_acc("R11", base + 2, nwp + 16'd30, 1'b0);
            end
        end

        // R4: craft a return frame to set a chosen status word
        stall = 1;
        poke(16'h0050, 16'h01E0);
        poke(16'h0052, 16'h2F00);
        do_call(16'h0050, 16'h3333);
        poke(16'h01FA, 16'h0120);
        poke(16'h01FC, 16'h4444);
        poke(16'h01FE, 16'hA50F);
        do_ret();
        chk("R4", "frame wp", wp, 16'h0120);
        chk("R4", "frame pc", pc, 16'h4444);
        chk("R4", "frame st", st, 16'hA50F);

        // R5: exhaustive sweep over interrupt levels
        for (int k = 1; k < 16; k++) begin
            stall = k % 3;
            poke(16'(4 * k), 16'h01C0);
            poke(16'(4 * k + 2), 16'h5000 + 16'(4 * k));
            ow = wp; op = pc; os = st;
            base = log_n;
            do_irq(4'(k));
            chk("R5", "irq wp", wp, 16'h01C0);
            chk("R5", "irq pc", pc, 16'h5000 + 16'(4 * k));
            chk("R5", "irq st", st, (os & 16'hFFF0) | 16'(k - 1));
            chk("R5", "irq saved wp", peek(16'h01DA), ow);
            chk("R5", "irq saved pc", peek(16'h01DC), op);
            chk("R5", "irq saved st", peek(16'h01DE), os);
            chk_acc("R5", base, 16'(4 * k), 1'b0);
            do_ret();
            chk("R5", "irq return st", st, os);
        end

        // R6: level 0 is refused
        stall = 0;
        base = log_n; ow = wp;
        irq_level = 4'd0; irq_req = 1'b1;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk("R6", "busy on level 0", {15'd0, busy}, 16'h0);
        end
        irq_req = 1'b0;
        chk("R6", "no access on level 0", 16'(log_n - base), 16'd0);
        chk("R6", "wp after level 0", wp, ow);

        // R6/R5: nested interrupts against a lowered mask
        do_irq(4'd3);
        chk("R5", "level 3 mask", st, 16'hA502);
        base = log_n; ow = wp; op = pc;
        irq_level = 4'd5; irq_req = 1'b1;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk("R6", "busy on masked level", {15'd0, busy}, 16'h0);
        end
        irq_req = 1'b0;
        chk("R6", "no access on masked level", 16'(log_n - base), 16'd0);
        chk("R6", "wp on masked level", wp, ow);
        chk("R6", "pc on masked level", pc, op);
        chk("R6", "st on masked level", st, 16'hA502);
        poke(16'h0008, 16'h0180);
        poke(16'h000A, 16'h6000);
        do_irq(4'd2);
        chk("R5", "nested wp", wp, 16'h0180);
        chk("R5", "nested st", st, 16'hA501);
        chk("R5", "nested saved wp", peek(16'h019A), 16'h01C0);
        chk("R5", "nested saved st", peek(16'h019E), 16'hA502);
        do_ret();
        chk("R4", "unwind 1 wp", wp, 16'h01C0);
        chk("R4", "unwind 1 st", st, 16'hA502);
        do_ret();
        chk("R4", "unwind 2 wp", wp, 16'h0120);
        chk("R4", "unwind 2 st", st, 16'hA50F);

        // R7: same-cycle collision, call wins and held irq follows
        poke(16'h0060, 16'h0100);
        poke(16'h0062, 16'h7000);
        base = log_n;
        call_vec = 16'h0060; call_link_pc = 16'h7777;
        call_req = 1'b1; ret_req = 1'b1; irq_level = 4'd4; irq_req = 1'b1;
        @(negedge clk);
        call_req = 1'b0; ret_req = 1'b0;
        wait_idle();
        chk("R7", "call wins wp", wp, 16'h0100);
        chk("R7", "call wins pc", pc, 16'h7000);
        chk_acc("R7", base, 16'h0060, 1'b0);
        @(negedge clk);
        irq_req = 1'b0;
        chk("R7", "held irq taken", {15'd0, busy}, 16'h1);
        wait_idle();
        chk("R7", "irq wp after call", wp, 16'h01C0);
        chk("R7", "irq saved caller wp", peek(16'h01DA), 16'h0100);
        do_ret();
        do_ret();
        chk("R7", "back to base wp", wp, 16'h0120);

        // R10: request during an operation is dropped
        stall = 2;
        call_vec = 16'h0060; call_link_pc = 16'h1234; call_req = 1'b1;
        @(negedge clk);
        call_req = 1'b0; ret_req = 1'b1;
        @(negedge clk);
        ret_req = 1'b0;
        wait_idle();
        @(negedge clk);
        chk("R10", "no extra operation", {15'd0, busy}, 16'h0);
        chk("R10", "wp kept", wp, 16'h0100);
        chk("R10", "pc kept", pc, 16'h7000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule